// File: doc/BRIEF.md
# Buffered ADC Trigger Comparator

This block sits beside a triangle-wave PWM carrier counter. It issues a one-clock A/D conversion start request when the counter value matches a programmable trigger position. Firmware never writes the active compare value directly. It writes a shadow buffer, and the buffer is copied into the active compare register only on a chosen carrier event: the crest (highest point), the trough (lowest point), or both. This lets trigger positions move between carrier periods without producing a torn or doubled trigger.

Each count direction has its own enable, so a trigger can be placed on the rising slope, on the falling slope, or on both. Two link enables can also tie the request to an external interrupt-skipping counter. That counter reports, at each crest or trough strobe, whether the period it opens is an unskipped one. The block keeps each verdict in a small two-state gate machine (GATE_SHUT, GATE_OPEN). The trigger machine has the states TRG_IDLE and TRG_PULSE. It moves from TRG_IDLE to TRG_PULSE on a qualified match. It returns to TRG_IDLE on the next cycle unless another qualified match arrives.

Top module: `adc_trig_cmp`

## Requirements
- R1: After reset the active compare value and the buffer are zero, both gate machines are GATE_SHUT, the trigger machine is TRG_IDLE and `adc_start` is 0.
- R2: A buffer write does not change the active compare value until a transfer event selects it; with `xfer_mode` = 2'b00 no transfer ever occurs.
- R3: `xfer_mode` selects the transfer event: 2'b01 copies on `crest_stb`, 2'b10 on `trough_stb`, 2'b11 on either strobe.
- R4: When `buf_wr` is high in the same cycle as a selected transfer strobe, the active compare value takes `buf_wdata` of that cycle.
- R5: `adc_start` is high for one clock in the cycle after a cycle in which `cnt_val` equals the active compare value and the request is qualified; otherwise it is low.
- R6: A match qualifies only if the enable for the current direction is set: `en_up` while `cnt_up` = 1, `en_down` while `cnt_up` = 0.
- R7: With `link_crest` = 1, a match qualifies only if `crest_unskip` was 1 at the most recent `crest_stb` (no crest since reset counts as skipped).
- R8: With `link_trough` = 1, a match qualifies only if `trough_unskip` was 1 at the most recent `trough_stb` (no trough since reset counts as skipped).
- R9: With a link enable at 0, the matching unskip input has no effect on `adc_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | CNT_W | Carrier counter value |
| cnt_up | input | 1 | 1 while the carrier counts up, 0 while it counts down |
| crest_stb | input | 1 | One-cycle strobe at the carrier crest |
| trough_stb | input | 1 | One-cycle strobe at the carrier trough |
| buf_wr | input | 1 | Write strobe for the shadow buffer |
| buf_wdata | input | CNT_W | Data written to the shadow buffer |
| xfer_mode | input | 2 | Transfer event select (00 none, 01 crest, 10 trough, 11 both) |
| en_up | input | 1 | Allow requests while counting up |
| en_down | input | 1 | Allow requests while counting down |
| link_crest | input | 1 | Tie requests to the crest skip verdict |
| link_trough | input | 1 | Tie requests to the trough skip verdict |
| crest_unskip | input | 1 | Skip verdict sampled at crest_stb (1 = period not skipped) |
| trough_unskip | input | 1 | Skip verdict sampled at trough_stb (1 = period not skipped) |
| adc_start | output | 1 | One-clock A/D conversion start request |

## Verification
On every cycle, the assertions check the following. Each pulse must trace back to a match against the active compare value one cycle earlier. The direction enable for that phase must have been set. Any linked gate must have been open. The active compare value must hold unless a selected strobe occurred. A write that coincides with a selected strobe must land directly in the active register. Only the bench scenarios show the rest. These include the selected strobe actually moving the trigger position over whole carrier periods, the effect of alternating skip verdicts across periods, and unlinked skip inputs leaving the pulse train unchanged.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    typedef enum logic [1:0] {
        XFER_NONE   = 2'b00,
        XFER_CREST  = 2'b01,
        XFER_TROUGH = 2'b10,
        XFER_BOTH   = 2'b11
    } xfer_mode_e;

    typedef enum logic {
        TRG_IDLE  = 1'b0,
        TRG_PULSE = 1'b1
    } trg_state_e;

    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_state_e;

    localparam int NUM_EVENTS = 2;
    localparam int EV_CREST   = 0;
    localparam int EV_TROUGH  = 1;

endpackage

// File: rtl/adc_trig_shadow.sv
module adc_trig_shadow
    import adc_trig_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   mode,
    input  logic         crest_stb,
    input  logic         trough_stb,
    output logic [W-1:0] cmp_q
);

    logic [W-1:0] buf_q;
    logic [W-1:0] buf_next;
    logic         xfer;
    xfer_mode_e   mode_e;

    assign mode_e   = xfer_mode_e'(mode);
    assign buf_next = wr_en ? wr_data : buf_q;

    // transfer event decode
    always_comb begin
        unique case (mode_e)
            XFER_NONE:   xfer = 1'b0;
            XFER_CREST:  xfer = crest_stb;
            XFER_TROUGH: xfer = trough_stb;
            XFER_BOTH:   xfer = crest_stb | trough_stb;
            default:     xfer = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_next;
        end
    end

    // a write in the transfer cycle goes straight through
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (xfer) begin
            cmp_q <= buf_next;
        end
    end

endmodule

// File: rtl/adc_trig_gate.sv
module adc_trig_gate
    import adc_trig_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] ev_stb,
    input  logic [NUM_EVENTS-1:0] ev_unskip,
    input  logic [NUM_EVENTS-1:0] ev_link,
    output logic [NUM_EVENTS-1:0] gate_open,
    output logic                  pass
);

    for (genvar g = 0; g < NUM_EVENTS; g++) begin : g_ev
        gate_state_e state_q;
        gate_state_e state_d;

        always_comb begin
            state_d = state_q;
            unique case (state_q)
                GATE_SHUT: if (ev_stb[g] && ev_unskip[g])  state_d = GATE_OPEN;
                GATE_OPEN: if (ev_stb[g] && !ev_unskip[g]) state_d = GATE_SHUT;
                default:   state_d = GATE_SHUT;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q <= GATE_SHUT;
            end else begin
                state_q <= state_d;
            end
        end

        assign gate_open[g] = (state_q == GATE_OPEN);
    end

    assign pass = &(~ev_link | gate_open);

endmodule

// File: rtl/adc_trig_fire.sv
module adc_trig_fire
    import adc_trig_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_val,
    input  logic [W-1:0] cmp_val,
    input  logic         cnt_up,
    input  logic         en_up,
    input  logic         en_down,
    input  logic         pass,
    output logic         start
);

    trg_state_e state_q;
    trg_state_e state_d;
    logic       hit;
    logic       dir_ok;

    assign dir_ok = cnt_up ? en_up : en_down;
    assign hit    = (cnt_val == cmp_val) && dir_ok && pass;

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRG_IDLE:  if (hit)  state_d = TRG_PULSE;
            TRG_PULSE: if (!hit) state_d = TRG_IDLE;
            default:   state_d = TRG_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output process
    always_comb begin
        unique case (state_q)
            TRG_PULSE: start = 1'b1;
            default:   start = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_trig_cmp.sv
module adc_trig_cmp
    import adc_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_up,
    input  logic             crest_stb,
    input  logic             trough_stb,
    input  logic             buf_wr,
    input  logic [CNT_W-1:0] buf_wdata,
    input  logic [1:0]       xfer_mode,
    input  logic             en_up,
    input  logic             en_down,
    input  logic             link_crest,
    input  logic             link_trough,
    input  logic             crest_unskip,
    input  logic             trough_unskip,
    output logic             adc_start
);

    logic [CNT_W-1:0]      cmp_q;
    logic [NUM_EVENTS-1:0] gate_open;
    logic                  gate_pass;

    adc_trig_shadow #(.W(CNT_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (buf_wr),
        .wr_data    (buf_wdata),
        .mode       (xfer_mode),
        .crest_stb  (crest_stb),
        .trough_stb (trough_stb),
        .cmp_q      (cmp_q)
    );

    adc_trig_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_stb    ({trough_stb, crest_stb}),
        .ev_unskip ({trough_unskip, crest_unskip}),
        .ev_link   ({link_trough, link_crest}),
        .gate_open (gate_open),
        .pass      (gate_pass)
    );

    adc_trig_fire #(.W(CNT_W)) u_fire (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_val (cnt_val),
        .cmp_val (cmp_q),
        .cnt_up  (cnt_up),
        .en_up   (en_up),
        .en_down (en_down),
        .pass    (gate_pass),
        .start   (adc_start)
    );

endmodule

// File: rtl/adc_trig_cmp_chk.sv
module adc_trig_cmp_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_val,
    input logic             cnt_up,
    input logic             crest_stb,
    input logic             trough_stb,
    input logic             buf_wr,
    input logic [CNT_W-1:0] buf_wdata,
    input logic [1:0]       xfer_mode,
    input logic             en_up,
    input logic             en_down,
    input logic             link_crest,
    input logic             link_trough,
    input logic             adc_start,
    input logic [CNT_W-1:0] cmp_q,
    input logic [1:0]       gate_open
);

    // R5: every pulse follows a match against the active value
    assert_pulse_on_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> ($past(cnt_val) == $past(cmp_q)));

    // R6: the direction enable of that phase was set
    assert_dir_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> $past(cnt_up ? en_up : en_down));

    // R2: active value holds without a selected strobe
    assert_cmp_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past((crest_stb && xfer_mode[0]) || (trough_stb && xfer_mode[1]))
        |-> (cmp_q == $past(cmp_q)));

    // R4: write coinciding with a selected strobe lands directly
    assert_write_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(buf_wr && ((crest_stb && xfer_mode[0]) || (trough_stb && xfer_mode[1])))
        |-> (cmp_q == $past(buf_wdata)));

    // R7: crest link blocks pulses in skipped periods
    assert_crest_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start && $past(link_crest)) |-> $past(gate_open[0]));

    // R8: trough link blocks pulses in skipped periods
    assert_trough_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_start && $past(link_trough)) |-> $past(gate_open[1]));

endmodule

bind adc_trig_cmp adc_trig_cmp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_val     (cnt_val),
    .cnt_up      (cnt_up),
    .crest_stb   (crest_stb),
    .trough_stb  (trough_stb),
    .buf_wr      (buf_wr),
    .buf_wdata   (buf_wdata),
    .xfer_mode   (xfer_mode),
    .en_up       (en_up),
    .en_down     (en_down),
    .link_crest  (link_crest),
    .link_trough (link_trough),
    .adc_start   (adc_start),
    .cmp_q       (cmp_q),
    .gate_open   (gate_open)
);

// File: tb/test_adc_trig_cmp.sv
module test_adc_trig_cmp;

    localparam int W     = 16;
    localparam int PEAK  = 20;
    localparam int LIMIT = 100000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt = '0;
    logic         cnt_up = 1'b1;
    logic         crest_stb = 1'b0;
    logic         trough_stb = 1'b0;
    logic         buf_wr = 1'b0;
    logic [W-1:0] buf_wdata = '0;
    logic [1:0]   xfer_mode = 2'b00;
    logic         en_up = 1'b0;
    logic         en_down = 1'b0;
    logic         link_crest = 1'b0;
    logic         link_trough = 1'b0;
    logic         crest_unskip = 1'b0;
    logic         trough_unskip = 1'b0;
    logic         adc_start;

    int    checks = 0;
    int    fails = 0;
    int    cycle = 0;
    bit    done = 1'b0;
    bit    rising = 1'b1;
    string tag = "R1";

    // reference model state
    int m_buf = 0;
    int m_cmp = 0;
    bit m_cok = 0;
    bit m_tok = 0;
    bit m_start = 0;

    always #5 clk = ~clk;

    adc_trig_cmp #(.CNT_W(W)) i_adc_trig_cmp (
        .clk           (clk),
        .rst_n         (rst_n),
        .cnt_val       (cnt),
        .cnt_up        (cnt_up),
        .crest_stb     (crest_stb),
        .trough_stb    (trough_stb),
        .buf_wr        (buf_wr),
        .buf_wdata     (buf_wdata),
        .xfer_mode     (xfer_mode),
        .en_up         (en_up),
        .en_down       (en_down),
        .link_crest    (link_crest),
        .link_trough   (link_trough),
        .crest_unskip  (crest_unskip),
        .trough_unskip (trough_unskip),
        .adc_start     (adc_start)
    );

    // behavioural reference, advanced on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_buf = 0; m_cmp = 0; m_cok = 0; m_tok = 0; m_start = 0;
        end else begin
            bit dir_ok, gate_ok, do_xfer;
            dir_ok  = cnt_up ? en_up : en_down;
            gate_ok = (!link_crest || m_cok) && (!link_trough || m_tok);
            m_start = (int'(cnt) == m_cmp) && dir_ok && gate_ok;
            do_xfer = (xfer_mode == 2'b01 && crest_stb) ||
                      (xfer_mode == 2'b10 && trough_stb) ||
                      (xfer_mode == 2'b11 && (crest_stb || trough_stb));
            if (buf_wr) m_buf = int'(buf_wdata);
            if (do_xfer) m_cmp = m_buf;
            if (crest_stb) m_cok = crest_unskip;
            if (trough_stb) m_tok = trough_unskip;
        end
    end

    // compare, then advance the triangle carrier
    task automatic tick();
        @(negedge clk);
        cycle++;
        checks++;
        if (adc_start !== m_start) begin
            fails++;
            $display("FAIL %s cycle %0d: adc_start actual %0b expected %0b",
                     tag, cycle, adc_start, m_start);
        end
        if (rising) cnt = cnt + 1'b1;
        else        cnt = cnt - 1'b1;
        if (int'(cnt) == PEAK) rising = 1'b0;
        else if (cnt == '0)   rising = 1'b1;
        cnt_up     = rising;
        crest_stb  = (int'(cnt) == PEAK);
        trough_stb = (cnt == '0);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic write_buf(int v);
        buf_wr = 1'b1;
        buf_wdata = W'(v);
        tick();
        buf_wr = 1'b0;
    endtask

    task automatic wait_crest();
        tick();
        while (!crest_stb) tick();
    endtask

    initial begin
        // R1: reset state, then compare value zero is live
        tag = "R1";
        run(4);
        rst_n = 1'b1;
        run(45);
        en_up = 1'b1;
        run(45);

        // R2: no transfer with mode 00
        tag = "R2";
        en_down = 1'b1;
        write_buf(7);
        run(90);

        // R3: crest, trough, both
        tag = "R3";
        xfer_mode = 2'b01;
        write_buf(7);
        run(85);
        xfer_mode = 2'b10;
        write_buf(12);
        run(85);
        xfer_mode = 2'b11;
        write_buf(5);
        run(85);

        // R4: write in the same cycle as the crest strobe
        tag = "R4";
        xfer_mode = 2'b01;
        wait_crest();
        buf_wr = 1'b1;
        buf_wdata = W'(9);
        tick();
        buf_wr = 1'b0;
        run(80);

        // R5/R6: direction enables
        tag = "R6";
        en_up = 1'b1; en_down = 1'b0;
        run(85);
        en_up = 1'b0; en_down = 1'b1;
        run(85);
        en_up = 1'b0; en_down = 1'b0;
        run(85);
        tag = "R5";
        en_up = 1'b1; en_down = 1'b1;
        xfer_mode = 2'b11;
        write_buf(PEAK);
        run(85);
        write_buf(0);
        run(85);
        write_buf(3);
        run(85);

        // R7: crest link with alternating verdicts
        tag = "R7";
        link_crest = 1'b1;
        for (int i = 0; i < 300; i++) begin
            tick();
            if (crest_stb) crest_unskip = ~crest_unskip;
        end
        link_crest = 1'b0;

        // R8: trough link with alternating verdicts
        tag = "R8";
        link_trough = 1'b1;
        for (int i = 0; i < 300; i++) begin
            tick();
            if (trough_stb) trough_unskip = ~trough_unskip;
        end
        link_trough = 1'b0;

        // R9: unlinked verdicts have no effect
        tag = "R9";
        for (int i = 0; i < 300; i++) begin
            tick();
            crest_unskip  = ~crest_unskip;
            trough_unskip = (i % 3) == 0;
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #(LIMIT * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule